// File: doc/BRIEF.md
# SPI Master Transmitter with Byte Queue

This block sends bytes from a host to a serial peripheral over a clock line and one data line. The host pushes bytes into an eight-entry queue through a write strobe. While the block is enabled, a shifter pulls bytes from the queue and sends each one most significant bit first. The serial clock comes from the system clock: each of its half periods lasts a programmable number of system cycles. Clock idle level and sampling edge can be set, which gives the usual four SPI modes.

The settings (idle level, sampling edge, half-period count) are taken only while the block is disabled and idle. The usual sequence is: clear the enable bit, set the configuration, then set the enable bit. The host drives the peripheral's select line itself. It writes only while the queue reports space. It treats a transfer as finished when the queue is empty and the busy output is low. Bytes that are queued together go out with no pause between them.

Top module: `spi_tx_master`

## Requirements
- R1: While not busy, `sclk` sits at the latched idle level: low when the latched `cfg_cpol` is 0, high when it is 1. The reset value of that level is 0.
- R2: With latched `cfg_cpha` = 0, the first bit of a byte is on `mosi` before the first clock edge. `mosi` changes only on trailing edges, so the receiver samples on leading edges. The leading edge is rising when the idle level is low and falling when it is high.
- R3: With latched `cfg_cpha` = 1, `mosi` changes on leading edges and holds steady across trailing edges, where the receiver samples.
- R4: Each byte is eight bits and is sent most significant bit first.
- R5: Each half period of `sclk` lasts `cfg_half` system cycles. A value of 1 gives a divide-by-2 clock, and 0 is treated as 1. The first edge comes one half period after the byte is loaded.
- R6: The queue holds 8 bytes. `not_full` is high exactly when fewer than 8 bytes are stored. A write while it is low is dropped.
- R7: When another byte is queued at the final edge of the current byte, that byte is loaded at that edge. The clock goes on without a gap, so N queued bytes keep `busy` high for N*16*`cfg_half` cycles.
- R8: `busy` rises in the cycle a byte is taken from the queue. It falls at the final trailing edge of the last byte, in the same cycle that `sclk` returns to idle. `mosi` changes only while busy.
- R9: Configuration inputs are latched only while `en` is low and the block is not busy. Changes made while enabled have no effect on `sclk` or on the bit timing.
- R10: No byte is taken from the queue while `en` is low. Queued bytes wait, and `busy` stays low.
- R11: After reset, `busy` is 0, `not_full` is 1, `sclk` is 0 and `mosi` is 0.
- R12: A write in the same cycle as a pop from a full queue is dropped. Fullness is judged before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables transmission; configuration is latched while low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_half | input | DIV_W | System cycles per serial clock half period |
| wr_en | input | 1 | Write strobe pushing `wr_data` into the queue |
| wr_data | input | DATA_W | Byte to queue |
| not_full | output | 1 | Queue can accept another byte |
| busy | output | 1 | Shifter is sending a byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |

## Verification
Two events can fall in the same cycle: a host write and a shifter pop. The pop happens either when idle and enabled or at the final edge of a byte. The bench fills the queue while disabled, then raises `en` and strobes a write in the same cycle. Because fullness is judged before the pop, that write must be dropped. A behavioural queue model, compared with the outputs on every clock, decides each such cycle. A bit-level receiver also checks that exactly the first eight bytes arrive.

// File: rtl/spi_tx_pkg.sv
// Package: shared types for the SPI transmitter.
// Assumes: nothing beyond IEEE 1800-2017 synthesis subset.
package spi_tx_pkg;

    // Shifter operating state
    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } sh_state_t;

    // Latched serial configuration
    typedef struct packed {
        logic cpol;
        logic cpha;
    } mode_cfg_t;

endpackage

// File: rtl/spi_tx_fifo.sv
// Module: spi_tx_fifo
// Synchronous byte queue with a registered occupancy count.
// Assumes: DEPTH is a power of two; pushes while full are dropped, pops
// are issued only while not empty; fullness is judged before any pop.
module spi_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          not_full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty    = (count == '0);
    assign not_full = (count != CW'(DEPTH));
    assign do_push  = push && not_full;
    assign do_pop   = pop && !empty;
    assign rdata    = mem[rd_ptr];

    // Store accepted bytes
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_tx_baud.sv
// Module: spi_tx_baud
// Emits a one-cycle tick at the end of every serial half period.
// Assumes: half == 0 is treated as 1; the counter stays cleared while not running.
module spi_tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (half == '0) ? '0 : half - 1'b1;
    assign tick  = run && (cnt == limit);

    // Count system cycles inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_tx_shifter.sv
// Module: spi_tx_shifter
// Pulls bytes from the queue and serialises them MSB first on sclk/mosi.
// Assumes: tick marks half-period ends; mode is stable while busy.
module spi_tx_shifter
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int EW    = $clog2(2 * DATA_W),
    localparam int LAST  = 2 * DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  mode_cfg_t         mode,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    output logic              pop,
    output logic              busy,
    output logic              sclk,
    output logic              mosi
);
    sh_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [EW-1:0]     edge_idx;
    logic              sclk_q;
    logic              mosi_q;
    logic              at_last;
    logic              leading;

    assign at_last = tick && (edge_idx == EW'(LAST));
    assign leading = !edge_idx[0];
    assign pop     = en && !q_empty && ((state == SH_IDLE) || at_last);
    assign busy    = (state == SH_SHIFT);
    assign sclk    = busy ? sclk_q : mode.cpol;
    assign mosi    = mosi_q;

    // Sequence the bit edges and the byte loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SH_IDLE;
            shreg    <= '0;
            edge_idx <= '0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (state == SH_IDLE) begin
            if (pop) begin
                state    <= SH_SHIFT;
                sclk_q   <= mode.cpol;
                edge_idx <= '0;
                if (!mode.cpha) begin
                    mosi_q <= q_data[DATA_W-1];
                    shreg  <= q_data << 1;
                end else begin
                    shreg  <= q_data;
                end
            end
        end else if (tick) begin
            sclk_q   <= !sclk_q;
            edge_idx <= edge_idx + 1'b1;
            if (leading) begin
                if (mode.cpha) begin
                    mosi_q <= shreg[DATA_W-1];
                    shreg  <= shreg << 1;
                end
            end else if (at_last) begin
                if (pop) begin
                    edge_idx <= '0;
                    if (!mode.cpha) begin
                        mosi_q <= q_data[DATA_W-1];
                        shreg  <= q_data << 1;
                    end else begin
                        shreg  <= q_data;
                    end
                end else begin
                    state <= SH_IDLE;
                end
            end else if (!mode.cpha) begin
                mosi_q <= shreg[DATA_W-1];
                shreg  <= shreg << 1;
            end
        end
    end
endmodule

// File: rtl/spi_tx_master.sv
// Module: spi_tx_master (top)
// SPI master transmitter: byte queue, half-period timer and shifter.
// Assumes: host drives the select line itself and writes only while not_full.
module spi_tx_master
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int DIV_W  = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              not_full,
    output logic              busy,
    output logic              sclk,
    output logic              mosi
);
    mode_cfg_t         mode_r;
    logic [DIV_W-1:0]  half_r;
    logic              q_empty;
    logic [DATA_W-1:0] q_data;
    logic [CW-1:0]     fifo_count;
    logic              pop;
    logic              tick;

    // Latch configuration only while disabled and idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            half_r <= DIV_W'(1);
        end else if (!en && !busy) begin
            mode_r.cpol <= cfg_cpol;
            mode_r.cpha <= cfg_cpha;
            half_r      <= cfg_half;
        end
    end

    spi_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .wdata    (wr_data),
        .pop      (pop),
        .rdata    (q_data),
        .empty    (q_empty),
        .not_full (not_full),
        .count    (fifo_count)
    );

    spi_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half_r),
        .tick  (tick)
    );

    spi_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode_r),
        .tick    (tick),
        .q_empty (q_empty),
        .q_data  (q_data),
        .pop     (pop),
        .busy    (busy),
        .sclk    (sclk),
        .mosi    (mosi)
    );
endmodule

// File: rtl/spi_tx_checker.sv
// Module: spi_tx_checker
// Temporal checks on the transmitter, bound into spi_tx_master.
// Assumes: synchronous active-low reset; past values used only after one clean cycle.
module spi_tx_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          busy,
    input logic          sclk,
    input logic          mosi,
    input logic [CW-1:0] fifo_count
);
    logic past_ok;

    // Mark cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r6_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    a_r8_mosi_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(mosi)) |-> busy);

    a_r8_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(sclk)) |-> (busy || $past(busy) || !$past(en)));

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && en && $past(en) && !busy && !$past(busy)) |-> $stable(sclk));

    a_r10_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(busy)) |-> $past(en));
endmodule

bind spi_tx_master spi_tx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .busy       (busy),
    .sclk       (sclk),
    .mosi       (mosi),
    .fifo_count (fifo_count)
);

// File: tb/spi_tx_master_tb.sv
module spi_tx_master_tb;
    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [DIV_W-1:0] cfg_half = 8'd1;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic not_full, busy, sclk, mosi;

    spi_tx_master #(.DATA_W(DW), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_half(cfg_half), .wr_en(wr_en), .wr_data(wr_data),
        .not_full(not_full), .busy(busy), .sclk(sclk), .mosi(mosi));

    int checks = 0, errors = 0;
    bit cmp_on = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int q[$];
    bit m_busy = 0, m_sclk = 0, m_mosi = 0, m_cpol = 0, m_cpha = 0;
    int m_half = 1, m_cnt = 0, m_edge = 0;
    logic [7:0] m_sh = '0;

    function automatic void m_load(int b);
        if (!m_cpha) begin m_mosi = b[7]; m_sh = 8'(b << 1); end
        else m_sh = 8'(b);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_sclk = 0; m_mosi = 0;
            m_cpol = 0; m_cpha = 0; m_half = 1; m_cnt = 0; m_edge = 0; m_sh = '0;
        end else begin
            bit was_full, was_busy;
            int lim;
            was_full = (q.size() == DEPTH);
            was_busy = m_busy;
            lim = (m_half == 0) ? 0 : m_half - 1;
            if (!was_busy) begin
                if (en && q.size() > 0) begin
                    m_busy = 1; m_sclk = m_cpol; m_edge = 0; m_cnt = 0;
                    m_load(q.pop_front());
                end
            end else if (m_cnt == lim) begin
                m_cnt = 0;
                m_sclk = !m_sclk;
                if (m_edge % 2 == 0) begin
                    if (m_cpha) begin m_mosi = m_sh[7]; m_sh = m_sh << 1; end
                    m_edge++;
                end else if (m_edge == 15) begin
                    if (en && q.size() > 0) begin m_edge = 0; m_load(q.pop_front()); end
                    else m_busy = 0;
                end else begin
                    if (!m_cpha) begin m_mosi = m_sh[7]; m_sh = m_sh << 1; end
                    m_edge++;
                end
            end else m_cnt++;
            if (!en && !was_busy) begin
                m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_half = int'(cfg_half);
            end
            if (wr_en && !was_full) q.push_back(int'(wr_data));
        end
    end

    // Receiver plus per-cycle comparison, away from the active edge
    int rx_q[$];
    int rx_bits = 0;
    logic [7:0] rx_cur = '0;
    bit prev_sclk = 0, prev_busy = 0;
    int busy_cycles = 0;

    always @(negedge clk) begin
        if (cmp_on) begin
            bit exp_sclk;
            exp_sclk = m_busy ? m_sclk : m_cpol;
            check(sclk === exp_sclk, "R5 R1 sclk", int'(sclk), int'(exp_sclk));
            check(mosi === m_mosi, "R4 mosi", int'(mosi), int'(m_mosi));
            check(busy === m_busy, "R8 busy", int'(busy), int'(m_busy));
            check(not_full === (q.size() < DEPTH), "R6 not_full", int'(not_full), int'(q.size() < DEPTH));
            if (busy) busy_cycles++;
            if (prev_busy && sclk !== prev_sclk) begin
                bit lead;
                lead = (prev_sclk == m_cpol);
                if (lead == !m_cpha) begin
                    rx_cur = {rx_cur[6:0], mosi};
                    rx_bits++;
                    if (rx_bits == 8) begin rx_q.push_back(int'(rx_cur)); rx_bits = 0; end
                end
            end
            prev_sclk = sclk;
            prev_busy = busy;
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    task automatic push_byte(input int b);
        @(negedge clk); wr_en = 1; wr_data = 8'(b);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy && q.size() == 0) break;
        end
        @(negedge clk);
    endtask

    task automatic set_cfg(input bit pol, input bit pha, input int h);
        @(negedge clk); en = 0; cfg_cpol = pol; cfg_cpha = pha; cfg_half = 8'(h);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_rx(input string tag, input int exp[$]);
        check(rx_q.size() == exp.size(), tag, rx_q.size(), exp.size());
        for (int i = 0; i < exp.size() && i < rx_q.size(); i++)
            check(rx_q[i] == exp[i], tag, rx_q[i], exp[i]);
        rx_q.delete(); rx_bits = 0;
    endtask

    initial begin
        int exp[$];
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy === 1'b0, "R11 busy", int'(busy), 0);
        check(not_full === 1'b1, "R11 not_full", int'(not_full), 1);
        check(sclk === 1'b0, "R11 sclk", int'(sclk), 0);
        check(mosi === 1'b0, "R11 mosi", int'(mosi), 0);
        rst_n = 1;
        @(negedge clk);
        prev_sclk = sclk; prev_busy = busy; cmp_on = 1;

        // R2 R4 R7: mode 0, divide-by-2, three bytes back to back
        set_cfg(0, 0, 1);
        exp = '{8'hA5, 8'h3C, 8'h81};
        foreach (exp[i]) push_byte(exp[i]);
        busy_cycles = 0;
        @(negedge clk); en = 1;
        wait_idle();
        check(busy_cycles == 48, "R7 busy span", busy_cycles, 48);
        check_rx("R2 R4 mode0 bytes", exp);

        // R3 R5 R1: idle high, trailing sample, half=3
        set_cfg(1, 1, 3);
        check(sclk === 1'b1, "R1 idle high", int'(sclk), 1);
        exp = '{8'h5A, 8'hF0};
        foreach (exp[i]) push_byte(exp[i]);
        @(negedge clk); en = 1;
        wait_idle();
        check_rx("R3 mode3 bytes", exp);

        // R5: half=0 treated as 1, idle high with leading sample
        set_cfg(1, 0, 0);
        exp = '{8'h96};
        busy_cycles = 0;
        push_byte(exp[0]);
        @(negedge clk); en = 1;
        wait_idle();
        check(busy_cycles == 16, "R5 half zero span", busy_cycles, 16);
        check_rx("R5 mode2 bytes", exp);

        // R6 R10: fill while disabled, ninth write dropped
        set_cfg(0, 1, 2);
        exp.delete();
        for (int i = 0; i < 9; i++) begin
            push_byte(16 + i);
            if (i < 8) exp.push_back(16 + i);
        end
        check(not_full === 1'b0, "R6 full flag", int'(not_full), 0);
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R10 held while disabled", int'(busy), 0);
        check(rx_q.size() == 0, "R10 nothing sent", rx_q.size(), 0);
        @(negedge clk); en = 1;
        wait_idle();
        check_rx("R6 eight bytes only", exp);

        // R9: configuration change while enabled is ignored
        set_cfg(0, 0, 1);
        @(negedge clk); en = 1; cfg_cpol = 1; cfg_cpha = 1; cfg_half = 8'd4;
        repeat (3) @(negedge clk);
        check(sclk === 1'b0, "R9 idle level kept", int'(sclk), 0);
        exp = '{8'hC3};
        busy_cycles = 0;
        push_byte(exp[0]);
        wait_idle();
        check(busy_cycles == 16, "R9 timing kept", busy_cycles, 16);
        check_rx("R9 mode kept", exp);
        @(negedge clk); en = 0;
        repeat (2) @(negedge clk);
        check(sclk === 1'b1, "R1 relatched idle", int'(sclk), 1);

        // R12: write in the cycle a full queue pops is dropped
        set_cfg(0, 0, 1);
        exp.delete();
        for (int i = 0; i < 8; i++) begin push_byte(64 + i); exp.push_back(64 + i); end
        @(negedge clk); en = 1; wr_en = 1; wr_data = 8'hEE;
        @(negedge clk); wr_en = 0;
        wait_idle();
        check_rx("R12 same-cycle write dropped", exp);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule